// File: doc/BRIEF.md
# Missing Clock Detector with Glitch-Free Failover

This block watches a primary oscillator clock using a free-running reference oscillator. A small counter driven by the primary clock wraps over and over. Each time it wraps, it restarts a much larger counter driven by the reference clock. If the primary stops, or runs at least about 64 times slower than the reference, the large counter reaches its terminal count and the primary is declared missing.

When the primary is declared missing, the block does the following:
- It sets a sticky status flag and raises a clock-fail output.
- It emits a one-cycle NMI/trip request.
- It asserts a bypass request toward the PLL.
- It forces the effective source select to the reference, whatever software has selected.

The same force also drives a break-before-make clock multiplexer. Its switch to the reference completes on the reference clock alone, so a dead primary cannot stall it.

Software re-arms the monitor with a write-one-to-clear pulse. That pulse clears the flag and both counters. A disable input parks the monitor without clearing a flag that is already set. Detection is enabled coming out of reset.

Top module: `mcd_failover`

## Requirements
- R1: While `rst_n` is low and just after it rises, `fail_flag`, `clk_fail`, `nmi_req` and `bypass_req` are 0, and `src_sel_eff` equals `usr_src_sel`.
- R2: A primary clock no slower than 50 reference periods per cycle never raises `fail_flag`.
- R3: With the primary stopped, `fail_flag` rises after a clear ends. This happens between 8100 and 8250 reference cycles later: 8192 counts plus synchronizer latency.
- R4: A primary running at 70 reference periods per cycle is detected as missing.
- R5: Detection is sticky and frozen. `fail_flag` and `clk_fail` stay high until a clear, the reference counter stops counting, and `nmi_req` is high for exactly one reference cycle per detection.
- R6: While `fail_flag` is 1, `bypass_req` is 1 and `src_sel_eff` is 1 (1 = reference, 0 = primary) regardless of `usr_src_sel`. The primary branch of the clock mux is off.
- R7: A `clr_req` pulse held at least 4 reference cycles clears `fail_flag` and `bypass_req`. It restarts both counters, and `src_sel_eff` then follows `usr_src_sel` again.
- R8: While `det_off` is 1, no new detection occurs and the reference counter is held at zero. A flag that is already set stays set.
- R9: The two clock-mux enables are never on together. With the source forced to the reference and the primary dead, `clk_out` toggles at the reference rate.
- R10: With `src_sel_eff` 0 and a running primary, `clk_out` toggles at the primary rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock being monitored |
| clk_ref | input | 1 | Free-running reference oscillator clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| det_off | input | 1 | 1 disables detection |
| clr_req | input | 1 | Write-one-to-clear pulse, held at least 4 reference cycles |
| usr_src_sel | input | 1 | Software source choice: 0 primary, 1 reference |
| fail_flag | output | 1 | Sticky missing-clock status |
| clk_fail | output | 1 | Clock-fail indication to trip logic |
| nmi_req | output | 1 | One-reference-cycle NMI/trip request |
| bypass_req | output | 1 | PLL bypass and multiplier-zero request |
| src_sel_eff | output | 1 | Effective source select after the override |
| clk_out | output | 1 | Glitch-free selected clock |

## Verification
A software clear can land in the same reference cycle in which the reference counter reaches its terminal count. The clear path must win: the flag must not survive and the monitor must re-arm.

The bench provokes this coincidence as follows. It stops the primary, clears once, and then issues a second clear timed to reach the reference domain within a cycle or two of the expected detection edge. It judges the result at the ports. After the clear completes, `fail_flag` and `bypass_req` must be low, and at most one NMI pulse may have been emitted. A later full dead-primary run must again detect within the R3 window.

// File: rtl/mcd_pkg.sv
// Shared types for the missing clock detector.
package mcd_pkg;
    // Source select encoding used on src_sel_eff and usr_src_sel.
    typedef enum logic {
        SRC_PRI = 1'b0,
        SRC_REF = 1'b1
    } src_e;
endpackage

// File: rtl/mcd_sync.sv
// Two-flop synchronizer, WIDTH independent bits.
// Assumes each bit is quasi-static or a toggle; no multi-bit coherency.
module mcd_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg;

    // Two flop stages for metastability settling.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
            q   <= '0;
        end else begin
            stg <= d;
            q   <= stg;
        end
    end
endmodule

// File: rtl/mcd_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on the second clk edge.
// Works when clk is stopped: the assert still reaches the output.
module mcd_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic stg;

    // Shift a one in after release, clear both flops at once on assert.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stg    <= 1'b0;
            srst_n <= 1'b0;
        end else begin
            stg    <= 1'b1;
            srst_n <= stg;
        end
    end
endmodule

// File: rtl/mcd_pri_cnt.sv
// Primary-domain wrap counter. Flips ovf_tgl each time the counter wraps,
// so the event can cross to the reference domain as a level change.
// Assumes arst_n may assert while clk_pri is dead.
module mcd_pri_cnt #(
    parameter int PCNT_W = 7
) (
    input  logic clk_pri,
    input  logic arst_n,
    output logic ovf_tgl
);
    localparam logic [PCNT_W-1:0] PCNT_TOP = {PCNT_W{1'b1}};

    logic              prst_n;
    logic [PCNT_W-1:0] pcnt;

    mcd_rst_sync u_rsync (
        .clk    (clk_pri),
        .arst_n (arst_n),
        .srst_n (prst_n)
    );

    // Free-running count; flip the toggle on every wrap.
    always_ff @(posedge clk_pri or negedge prst_n) begin
        if (!prst_n) begin
            pcnt    <= '0;
            ovf_tgl <= 1'b0;
        end else begin
            pcnt <= pcnt + 1'b1;
            if (pcnt == PCNT_TOP) begin
                ovf_tgl <= ~ovf_tgl;
            end
        end
    end
endmodule

// File: rtl/mcd_ref_core.sv
// Reference-domain detector. It restarts its counter on each primary wrap
// seen through the toggle, and sets the sticky flag on terminal count.
// After detection the counter freezes. Clear has priority over everything,
// then disable. Assumes clr_req is held at least 4 reference cycles.
module mcd_ref_core #(
    parameter int RCNT_W = 13
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              ovf_tgl,
    input  logic              clr_req,
    input  logic              det_off,
    output logic              fail_flag,
    output logic              nmi_req,
    output logic              clr_s
);
    localparam logic [RCNT_W-1:0] RCNT_TOP = {RCNT_W{1'b1}};

    logic              tgl_s;
    logic              off_s;
    logic              tgl_d;
    logic              restart;
    logic [RCNT_W-1:0] ref_cnt;

    mcd_sync #(.WIDTH(3)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     ({ovf_tgl, clr_req, det_off}),
        .q     ({tgl_s, clr_s, off_s})
    );

    // Delay the synchronized toggle to find its edges.
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) tgl_d <= 1'b0;
        else        tgl_d <= tgl_s;
    end

    assign restart = tgl_s ^ tgl_d;

    // Count, restart, freeze, and raise the sticky flag plus one NMI pulse.
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt   <= '0;
            fail_flag <= 1'b0;
            nmi_req   <= 1'b0;
        end else begin
            nmi_req <= 1'b0;
            if (clr_s) begin
                ref_cnt   <= '0;
                fail_flag <= 1'b0;
            end else if (off_s) begin
                ref_cnt <= '0;
            end else if (fail_flag) begin
                ref_cnt <= ref_cnt;
            end else if (restart) begin
                ref_cnt <= '0;
            end else if (ref_cnt == RCNT_TOP) begin
                ref_cnt   <= '0;
                fail_flag <= 1'b1;
                nmi_req   <= 1'b1;
            end else begin
                ref_cnt <= ref_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcd_clk_mux.sv
// Break-before-make two-input clock mux. Each branch enable is a flop pair
// in its own clock domain. force_ref clears the primary branch
// asynchronously, so a failover never waits on primary edges.
// Assumes force_ref comes from a reference-domain flop.
module mcd_clk_mux (
    input  logic clk_pri,
    input  logic clk_ref,
    input  logic rst_n,
    input  logic force_ref,
    input  logic sel_ref,
    output logic clk_out
);
    logic pri_clr_n;
    logic p_stg;
    logic en_p;
    logic r_stg;
    logic en_r;

    assign pri_clr_n = rst_n & ~force_ref;

    // Primary request stage: wants primary and the reference branch is off.
    always_ff @(posedge clk_pri or negedge pri_clr_n) begin
        if (!pri_clr_n) p_stg <= 1'b0;
        else            p_stg <= ~sel_ref & ~en_r;
    end

    // Primary enable changes only while clk_pri is low.
    always_ff @(negedge clk_pri or negedge pri_clr_n) begin
        if (!pri_clr_n) en_p <= 1'b0;
        else            en_p <= p_stg;
    end

    // Reference request stage: wants reference and the primary branch is off.
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) r_stg <= 1'b0;
        else        r_stg <= sel_ref & ~en_p;
    end

    // Reference enable changes only while clk_ref is low.
    always_ff @(negedge clk_ref or negedge rst_n) begin
        if (!rst_n) en_r <= 1'b0;
        else        en_r <= r_stg;
    end

    assign clk_out = (clk_pri & en_p) | (clk_ref & en_r);
endmodule

// File: rtl/mcd_failover.sv
// Top of the missing clock detector with forced failover.
// The primary-domain counter is cleared by the reference-synchronized clear
// level, using async assert and sync release. The status flag forces the
// source select and PLL bypass request.
module mcd_failover #(
    parameter int PCNT_W = 7,
    parameter int RCNT_W = 13
) (
    input  logic clk_pri,
    input  logic clk_ref,
    input  logic rst_n,
    input  logic det_off,
    input  logic clr_req,
    input  logic usr_src_sel,
    output logic fail_flag,
    output logic clk_fail,
    output logic nmi_req,
    output logic bypass_req,
    output logic src_sel_eff,
    output logic clk_out
);
    import mcd_pkg::*;

    logic ovf_tgl;
    logic clr_s;
    logic pri_arst_n;
    logic sel_ref;

    assign pri_arst_n = rst_n & ~clr_s;

    mcd_pri_cnt #(.PCNT_W(PCNT_W)) u_pri (
        .clk_pri (clk_pri),
        .arst_n  (pri_arst_n),
        .ovf_tgl (ovf_tgl)
    );

    mcd_ref_core #(.RCNT_W(RCNT_W)) u_core (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .ovf_tgl   (ovf_tgl),
        .clr_req   (clr_req),
        .det_off   (det_off),
        .fail_flag (fail_flag),
        .nmi_req   (nmi_req),
        .clr_s     (clr_s)
    );

    assign clk_fail    = fail_flag;
    assign bypass_req  = fail_flag;
    assign src_sel_eff = fail_flag ? SRC_REF : usr_src_sel;
    assign sel_ref     = (src_e'(src_sel_eff) == SRC_REF);

    mcd_clk_mux u_mux (
        .clk_pri   (clk_pri),
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .force_ref (fail_flag),
        .sel_ref   (sel_ref),
        .clk_out   (clk_out)
    );
endmodule

// File: rtl/mcd_failover_chk.sv
// Property checker for mcd_failover, attached by bind.
module mcd_failover_chk #(
    parameter int RCNT_W = 13
) (
    input logic              clk_ref,
    input logic              rst_n,
    input logic              fail_flag,
    input logic              nmi_req,
    input logic              clr_s,
    input logic              off_s,
    input logic [RCNT_W-1:0] ref_cnt,
    input logic              en_p,
    input logic              en_r
);
    assert_nmi_single_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    assert_nmi_on_rise_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(fail_flag) |-> nmi_req);

    assert_flag_sticky_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (fail_flag && !clr_s) |=> fail_flag);

    assert_cnt_frozen_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (fail_flag && !clr_s && !off_s) |=> $stable(ref_cnt));

    assert_off_hold_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        off_s |=> (ref_cnt == '0));

    assert_off_no_set_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (off_s && !fail_flag) |=> !fail_flag);

    assert_pri_branch_off_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fail_flag |-> !en_p);

    assert_mux_exclusive_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(en_p && en_r));
endmodule

bind mcd_failover mcd_failover_chk #(.RCNT_W(RCNT_W)) u_chk (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .fail_flag (fail_flag),
    .nmi_req   (nmi_req),
    .clr_s     (u_core.clr_s),
    .off_s     (u_core.off_s),
    .ref_cnt   (u_core.ref_cnt),
    .en_p      (u_mux.en_p),
    .en_r      (u_mux.en_r)
);

// File: tb/sim_mcd_failover.sv
`timescale 1ns/1ps
module sim_mcd_failover;
    logic clk_pri, clk_ref, rst_n;
    logic det_off, clr_req, usr_src_sel;
    logic fail_flag, clk_fail, nmi_req, bypass_req, src_sel_eff, clk_out;

    int pri_hp = 1;
    int checks = 0;
    int fails  = 0;
    int nmi_cnt = 0;
    int out_edges = 0;

    // Vector table: primary half period (ns, 0 = stopped), disable, expected detection.
    localparam int NV = 5;
    localparam int VHP  [NV] = '{1, 100, 140, 0, 0};
    localparam bit VOFF [NV] = '{0, 0, 0, 0, 1};
    localparam bit VEXP [NV] = '{0, 0, 1, 1, 0};

    mcd_failover u0 (
        .clk_pri(clk_pri), .clk_ref(clk_ref), .rst_n(rst_n),
        .det_off(det_off), .clr_req(clr_req), .usr_src_sel(usr_src_sel),
        .fail_flag(fail_flag), .clk_fail(clk_fail), .nmi_req(nmi_req),
        .bypass_req(bypass_req), .src_sel_eff(src_sel_eff), .clk_out(clk_out)
    );

    initial begin
        clk_ref = 1'b0;
        forever #2 clk_ref = ~clk_ref;
    end

    initial begin
        clk_pri = 1'b0;
        forever begin
            if (pri_hp == 0) #1;
            else begin
                #(pri_hp * 1ns);
                clk_pri = ~clk_pri;
            end
        end
    end

    always @(negedge clk_ref) if (nmi_req === 1'b1) nmi_cnt++;
    always @(posedge clk_out) out_edges++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic do_clear();
        @(negedge clk_ref);
        clr_req = 1'b1;
        wait_ref(4);
        clr_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(150000 * 4ns);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n0, e0;
        rst_n = 1'b0; det_off = 1'b0; clr_req = 1'b0; usr_src_sel = 1'b0;
        wait_ref(10);
        // R1: reset state
        chk(fail_flag == 0 && clk_fail == 0, "R1 flags in reset", fail_flag, 0);
        chk(nmi_req == 0 && bypass_req == 0, "R1 nmi/bypass in reset", nmi_req, 0);
        chk(src_sel_eff == usr_src_sel, "R1 src follows user", src_sel_eff, usr_src_sel);
        rst_n = 1'b1;
        wait_ref(3);
        chk(fail_flag == 0 && bypass_req == 0, "R1 after release", fail_flag, 0);

        // Vector walk: R2 (fast / 50x), R4 (70x), R3 (stopped), R8 (disabled)
        for (int i = 0; i < NV; i++) begin
            pri_hp  = VHP[i];
            det_off = VOFF[i];
            do_clear();
            n0 = nmi_cnt;
            wait_ref(10000);
            chk(fail_flag == VEXP[i], $sformatf("R2 R3 R4 R8 vector %0d flag", i),
                fail_flag, VEXP[i]);
            chk(clk_fail == VEXP[i], $sformatf("R5 vector %0d clk_fail", i),
                clk_fail, VEXP[i]);
            chk((nmi_cnt - n0) == int'(VEXP[i]), $sformatf("R5 vector %0d nmi pulses", i),
                nmi_cnt - n0, VEXP[i]);
        end

        // R3: latency window with a stopped primary
        det_off = 1'b0;
        pri_hp  = 0;
        do_clear();
        n0 = nmi_cnt;
        wait_ref(8100);
        chk(fail_flag == 0, "R3 no detection before 8100", fail_flag, 0);
        wait_ref(150);
        chk(fail_flag == 1, "R3 detection by 8250", fail_flag, 1);
        chk((nmi_cnt - n0) == 1, "R5 single nmi pulse", nmi_cnt - n0, 1);

        // R6: override of source and bypass while flagged
        chk(bypass_req == 1 && src_sel_eff == 1, "R6 forced to reference", src_sel_eff, 1);
        usr_src_sel = 1'b1;
        wait_ref(2);
        usr_src_sel = 1'b0;
        wait_ref(2);
        chk(src_sel_eff == 1, "R6 user select ignored", src_sel_eff, 1);

        // R9: forced output follows the reference with a dead primary
        e0 = out_edges;
        wait_ref(200);
        chk((out_edges - e0) >= 198 && (out_edges - e0) <= 202, "R9 clk_out at reference rate",
            out_edges - e0, 200);

        // R8: disable does not clear an existing flag
        det_off = 1'b1;
        wait_ref(20);
        chk(fail_flag == 1 && bypass_req == 1, "R8 flag kept under disable", fail_flag, 1);
        det_off = 1'b0;
        wait_ref(5);
        chk(fail_flag == 1, "R5 flag sticky", fail_flag, 1);

        // Clear colliding with a terminal count: the clear must win (R7)
        do_clear();
        n0 = nmi_cnt;
        wait_ref(8188);
        do_clear();
        wait_ref(4);
        chk(fail_flag == 0 && bypass_req == 0, "R7 clear vs detection", fail_flag, 0);
        chk((nmi_cnt - n0) <= 1, "R5 at most one nmi in collision", nmi_cnt - n0, 1);

        // R7 and R10: clear with a running primary, output follows the primary
        pri_hp = 0;
        wait_ref(8300);
        pri_hp = 5;
        do_clear();
        wait_ref(30);
        chk(fail_flag == 0 && bypass_req == 0, "R7 flag cleared", fail_flag, 0);
        chk(src_sel_eff == usr_src_sel, "R7 src back to user", src_sel_eff, usr_src_sel);
        wait_ref(100);
        e0 = out_edges;
        wait_ref(200);
        chk((out_edges - e0) >= 78 && (out_edges - e0) <= 82, "R10 clk_out at primary rate",
            out_edges - e0, 80);
        wait_ref(10000);
        chk(fail_flag == 0, "R2 healthy primary after re-arm", fail_flag, 0);

        finish_run();
    end
endmodule